// File: doc/BRIEF.md
# Timekeeper Alarm Repeat Unit

This block keeps the four alarm compare registers of a battery-backed real-time clock: second, minute, hour and day of month, each held as BCD with a mask flag in bit 7. A separate time-of-day counter supplies the current BCD fields and a one-cycle tick once per second. On each tick the unit compares the unmasked alarm fields with the current time. When the programmed condition holds, it emits a single-cycle interrupt pulse.

The mask flags set how often the alarm repeats. With no flags set it fires once a month. With the day flag alone it fires daily. Day and hour flags give an hourly alarm, and day, hour and minute flags give one each minute. Every other pattern of flags makes it fire on every tick. Writes to the seconds, minutes and hours registers are checked against the BCD range of the field, and a write out of range is dropped. The register ports are plain strobed control pins with no back-pressure: a write takes effect in the cycle it is strobed and a read is combinational. No data stream passes through the block, so it has no valid/ready interface.

Top module: `timekeeper_alarm`

## Requirements
- R1: After reset all four registers read 0x00 and `irq_pulse` is low.
- R2: `rd_data` returns the full stored byte of the register chosen by `rd_idx`, combinationally. Index 0 selects seconds, 1 minutes, 2 hours and 3 day of month.
- R3: A seconds or minutes write (index 0 or 1) is stored only when bits 3:0 are at most 9 and bits 6:4 are at most 5. Otherwise the register keeps its old value.
- R4: An hours write (index 2) is stored only when bits 5:0 form BCD 00 to 23: the units digit in bits 3:0 is at most 9 and the tens digit in bits 5:4 is 0 or 1, or the tens digit is 2 and the units digit is at most 3. Otherwise the register keeps its old value.
- R5: A day write (index 3) is always stored as the full byte. Only bits 5:0 take part in matching.
- R6: No interrupt is raised after reset until a write strobe has been seen. Any strobe arms the unit, including one whose value is rejected.
- R7: With all four mask bits (bit 7) clear, a tick fires only when day, hour, minute and second all match. Seconds and minutes compare bits 6:0, and hour and day compare bits 5:0.
- R8: With only the day mask set, a tick fires when hour, minute and second match.
- R9: With the day and hour masks set and the others clear, a tick fires when minute and second match.
- R10: With the day, hour and minute masks set and the seconds mask clear, a tick fires when the second matches.
- R11: With any other mask pattern, every tick fires once the unit is armed.
- R12: `irq_pulse` is high for exactly the one cycle after the clock edge that samples a firing tick, and it is low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 2 | Register index for write |
| wr_data | input | 8 | Write byte (bit 7 mask, low bits BCD) |
| rd_idx | input | 2 | Register index for read |
| rd_data | output | 8 | Stored byte of selected register |
| sec_tick | input | 1 | One-cycle strobe once per second |
| cur_sec | input | 7 | Current BCD second |
| cur_min | input | 7 | Current BCD minute |
| cur_hour | input | 6 | Current BCD hour |
| cur_date | input | 6 | Current BCD day of month |
| irq_pulse | output | 1 | Single-cycle alarm interrupt |

## Verification
The bound checker evaluates these properties on every cycle:
- every pulse follows a tick while the unit is armed;
- out-of-range seconds and hours writes leave the register unchanged;
- day writes store the whole byte;
- the all-masks pattern fires on every tick;
- a month-mode pulse implies that day and second matched.

The bench scenarios cover the rest, because those properties depend on chosen register contents and time values:
- the day, hour and minute repeat patterns, including ticks that miss by one field;
- mixed mask patterns that fall back to firing on every tick;
- the arming after reset, including arming by a rejected write.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
  localparam int NREG   = 4;
  localparam int BYTE_W = 8;
  localparam int IDX_W  = $clog2(NREG);

  typedef enum logic [IDX_W-1:0] {
    IDX_SEC  = 2'd0,
    IDX_MIN  = 2'd1,
    IDX_HOUR = 2'd2,
    IDX_DATE = 2'd3
  } alarm_idx_e;

  typedef enum logic [2:0] {
    RPT_MONTH,
    RPT_DAY,
    RPT_HOUR,
    RPT_MINUTE,
    RPT_SECOND
  } repeat_e;
endpackage

// File: rtl/alarm_wr_filter.sv
module alarm_wr_filter
  import alarm_pkg::*;
(
  input  alarm_idx_e idx,
  input  logic [6:0] val,
  output logic       accept
);
  logic [3:0] ones;
  logic [2:0] tens_ms;
  logic [1:0] tens_h;
  logic       ones_ok;

  assign ones    = val[3:0];
  assign tens_ms = val[6:4];
  assign tens_h  = val[5:4];
  assign ones_ok = (ones <= 4'd9);

  always_comb begin
    unique case (idx)
      IDX_SEC, IDX_MIN: accept = ones_ok && (tens_ms <= 3'd5);
      IDX_HOUR:         accept = ones_ok &&
                                 ((tens_h < 2'd2) || (tens_h == 2'd2 && ones <= 4'd3));
      default:          accept = 1'b1;
    endcase
  end
endmodule

// File: rtl/alarm_regbank.sv
module alarm_regbank
  import alarm_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_go,
  input  logic [IDX_W-1:0]             wr_idx,
  input  logic [BYTE_W-1:0]            wr_data,
  output logic [NREG-1:0][BYTE_W-1:0]  regs
);
  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)
        regs[i] <= '0;
      else if (wr_go && wr_idx == IDX_W'(i))
        regs[i] <= wr_data;
    end
  end
endmodule

// File: rtl/alarm_matcher.sv
module alarm_matcher
  import alarm_pkg::*;
(
  input  logic [NREG-1:0][BYTE_W-1:0] regs,
  input  logic [6:0]                  cur_sec,
  input  logic [6:0]                  cur_min,
  input  logic [5:0]                  cur_hour,
  input  logic [5:0]                  cur_date,
  output repeat_e                     mode,
  output logic                        hit
);
  logic [NREG-1:0] masks;
  logic eq_s, eq_m, eq_h, eq_d;

  for (genvar i = 0; i < NREG; i++) begin : g_mask
    assign masks[i] = regs[i][BYTE_W-1];
  end

  assign eq_s = (regs[IDX_SEC][6:0]  == cur_sec);
  assign eq_m = (regs[IDX_MIN][6:0]  == cur_min);
  assign eq_h = (regs[IDX_HOUR][5:0] == cur_hour);
  assign eq_d = (regs[IDX_DATE][5:0] == cur_date);

  always_comb begin
    case (masks)
      4'b0000: mode = RPT_MONTH;
      4'b1000: mode = RPT_DAY;
      4'b1100: mode = RPT_HOUR;
      4'b1110: mode = RPT_MINUTE;
      default: mode = RPT_SECOND;
    endcase
  end

  always_comb begin
    unique case (mode)
      RPT_MONTH:  hit = eq_d && eq_h && eq_m && eq_s;
      RPT_DAY:    hit = eq_h && eq_m && eq_s;
      RPT_HOUR:   hit = eq_m && eq_s;
      RPT_MINUTE: hit = eq_s;
      default:    hit = 1'b1;
    endcase
  end
endmodule

// File: rtl/timekeeper_alarm.sv
module timekeeper_alarm
  import alarm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [BYTE_W-1:0] rd_data,
  input  logic              sec_tick,
  input  logic [6:0]        cur_sec,
  input  logic [6:0]        cur_min,
  input  logic [5:0]        cur_hour,
  input  logic [5:0]        cur_date,
  output logic              irq_pulse
);
  logic [NREG-1:0][BYTE_W-1:0] regs;
  logic    accept;
  logic    hit;
  logic    armed_q;
  logic    irq_q;
  repeat_e mode;

  alarm_wr_filter u_filter (
    .idx    (alarm_idx_e'(wr_idx)),
    .val    (wr_data[6:0]),
    .accept (accept)
  );

  alarm_regbank u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_go   (wr_en && accept),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .regs    (regs)
  );

  alarm_matcher u_match (
    .regs     (regs),
    .cur_sec  (cur_sec),
    .cur_min  (cur_min),
    .cur_hour (cur_hour),
    .cur_date (cur_date),
    .mode     (mode),
    .hit      (hit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      if (wr_en) armed_q <= 1'b1;
      irq_q <= sec_tick && armed_q && hit;
    end
  end

  assign rd_data   = regs[rd_idx];
  assign irq_pulse = irq_q;
endmodule

// File: rtl/alarm_checker.sv
module alarm_checker
  import alarm_pkg::*;
(
  input logic                        clk,
  input logic                        rst_n,
  input logic                        wr_en,
  input logic [IDX_W-1:0]            wr_idx,
  input logic [BYTE_W-1:0]           wr_data,
  input logic                        sec_tick,
  input logic [6:0]                  cur_sec,
  input logic [5:0]                  cur_date,
  input logic                        armed,
  input logic [NREG-1:0][BYTE_W-1:0] regs,
  input logic                        irq_pulse
);
  a_r12_pulse_follows_tick: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> $past(sec_tick));

  a_r6_pulse_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> $past(armed));

  a_r3_sec_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == 2'd0 && (wr_data[3:0] > 4'd9 || wr_data[6:4] > 3'd5))
    |=> $stable(regs[0]));

  a_r4_hour_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == 2'd2 &&
     (wr_data[3:0] > 4'd9 || wr_data[5:4] == 2'd3 ||
      (wr_data[5:4] == 2'd2 && wr_data[3:0] > 4'd3)))
    |=> $stable(regs[2]));

  a_r5_date_store: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == 2'd3) |=> (regs[3] == $past(wr_data)));

  a_r11_all_masked_fires: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && armed && regs[0][7] && regs[1][7] && regs[2][7] && regs[3][7])
    |=> irq_pulse);

  a_r7_month_needs_match: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pulse && $past({regs[3][7], regs[2][7], regs[1][7], regs[0][7]} == 4'b0000))
    |-> $past(regs[3][5:0] == cur_date && regs[0][6:0] == cur_sec));
endmodule

bind timekeeper_alarm alarm_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .wr_idx    (wr_idx),
  .wr_data   (wr_data),
  .sec_tick  (sec_tick),
  .cur_sec   (cur_sec),
  .cur_date  (cur_date),
  .armed     (armed_q),
  .regs      (regs),
  .irq_pulse (irq_pulse)
);

// File: tb/tb_timekeeper_alarm.sv
`timescale 1ns/1ps
module tb_timekeeper_alarm;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_idx = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] rd_idx = '0;
  logic [7:0] rd_data;
  logic       sec_tick = 1'b0;
  logic [6:0] cur_sec = '0;
  logic [6:0] cur_min = '0;
  logic [5:0] cur_hour = '0;
  logic [5:0] cur_date = '0;
  logic       irq_pulse;
  logic       tick_q = 1'b0;

  int    n_checks = 0;
  int    n_fails  = 0;
  bit    exp_q[$];
  string tag_q[$];

  always #4 clk = ~clk;

  timekeeper_alarm dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(rd_idx), .rd_data(rd_data), .sec_tick(sec_tick), .cur_sec(cur_sec),
    .cur_min(cur_min), .cur_hour(cur_hour), .cur_date(cur_date), .irq_pulse(irq_pulse)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] i, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = i; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [1:0] i, logic [7:0] exp, string req);
    rd_idx = i;
    #1;
    check(req, rd_data, exp);
  endtask

  task automatic set_time(logic [5:0] d, logic [5:0] h, logic [6:0] m, logic [6:0] s);
    @(negedge clk);
    cur_date = d; cur_hour = h; cur_min = m; cur_sec = s;
  endtask

  // driver: pushes the expected outcome, then strobes the tick
  task automatic tick(bit exp, string req);
    @(negedge clk);
    exp_q.push_back(exp);
    tag_q.push_back(req);
    sec_tick = 1'b1;
    @(negedge clk);
    sec_tick = 1'b0;
    @(negedge clk);
  endtask

  always @(posedge clk) tick_q <= sec_tick;

  // monitor: compares the pulse one cycle after each sampled tick, idle otherwise
  always @(negedge clk) begin
    if (rst_n) begin
      if (tick_q) begin
        if (exp_q.size() == 0) begin
          n_checks++; n_fails++;
          $display("FAIL R12 actual=unexpected tick expected=queued item");
        end else begin
          automatic bit    e = exp_q.pop_front();
          automatic string t = tag_q.pop_front();
          check(t, {7'd0, irq_pulse}, {7'd0, e});
        end
      end else begin
        check("R12 idle", {7'd0, irq_pulse}, 8'h00);
      end
    end
  end

  initial begin
    #(8ns * 200000);
    n_checks++; n_fails++;
    $display("FAIL R12 watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    for (int i = 0; i < 4; i++) rd(2'(i), 8'h00, "R1 reg after reset");
    check("R1 irq after reset", {7'd0, irq_pulse}, 8'h00);
    // R6: all-zero alarm matches zero time, but unit is not armed
    set_time(6'h00, 6'h00, 7'h00, 7'h00);
    tick(1'b0, "R6 unarmed");

    // R3 seconds/minutes range
    wr(2'd0, 8'h30); rd(2'd0, 8'h30, "R3 sec accept");
    wr(2'd0, 8'h60); rd(2'd0, 8'h30, "R3 sec tens reject");
    wr(2'd0, 8'h3A); rd(2'd0, 8'h30, "R3 sec units reject");
    wr(2'd1, 8'h59); rd(2'd1, 8'h59, "R3 min accept");
    wr(2'd1, 8'h5A); rd(2'd1, 8'h59, "R3 min reject");
    // R4 hour range
    wr(2'd2, 8'h23); rd(2'd2, 8'h23, "R4 hour 23 accept");
    wr(2'd2, 8'h24); rd(2'd2, 8'h23, "R4 hour 24 reject");
    wr(2'd2, 8'h1A); rd(2'd2, 8'h23, "R4 hour units reject");
    wr(2'd2, 8'h19); rd(2'd2, 8'h19, "R4 hour 19 accept");
    wr(2'd2, 8'h23);
    // R5 date stores full byte
    wr(2'd3, 8'hFF); rd(2'd3, 8'hFF, "R5 date full byte");
    wr(2'd3, 8'h15); rd(2'd3, 8'h15, "R5 date value");

    // R7 month mode
    set_time(6'h15, 6'h23, 7'h59, 7'h30); tick(1'b1, "R7 full match");
    set_time(6'h15, 6'h23, 7'h59, 7'h31); tick(1'b0, "R7 second miss");
    set_time(6'h16, 6'h23, 7'h59, 7'h30); tick(1'b0, "R7 date miss");
    // R8 day mode
    wr(2'd3, 8'h81);
    set_time(6'h16, 6'h23, 7'h59, 7'h30); tick(1'b1, "R8 daily match");
    set_time(6'h16, 6'h22, 7'h59, 7'h30); tick(1'b0, "R8 hour miss");
    // R9 hour mode
    wr(2'd2, 8'h85);
    set_time(6'h16, 6'h10, 7'h59, 7'h30); tick(1'b1, "R9 hourly match");
    set_time(6'h16, 6'h10, 7'h58, 7'h30); tick(1'b0, "R9 minute miss");
    // R10 minute mode
    wr(2'd1, 8'h80);
    set_time(6'h16, 6'h10, 7'h12, 7'h30); tick(1'b1, "R10 minutely match");
    set_time(6'h16, 6'h10, 7'h12, 7'h29); tick(1'b0, "R10 second miss");
    // R11 other patterns
    wr(2'd0, 8'hB0);
    tick(1'b1, "R11 all masks");
    wr(2'd3, 8'h15); wr(2'd2, 8'h23); wr(2'd1, 8'h59);
    set_time(6'h01, 6'h00, 7'h00, 7'h00); tick(1'b1, "R11 seconds mask only");
    wr(2'd0, 8'h30); wr(2'd2, 8'hA3);
    rd(2'd2, 8'hA3, "R2 hour readback with mask");
    tick(1'b1, "R11 hour mask only");

    // reset again, then arm through a rejected write
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    rd(2'd2, 8'h00, "R1 hour after second reset");
    set_time(6'h00, 6'h00, 7'h00, 7'h00);
    tick(1'b0, "R6 unarmed after reset");
    wr(2'd0, 8'h7A); rd(2'd0, 8'h00, "R3 rejected arming write");
    tick(1'b1, "R6 armed by rejected write");
    repeat (3) @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule